// File: doc/BRIEF.md
# Redundant-Weight Successive-Approximation Conversion Controller

This block sequences a synchronous successive-approximation conversion for a differential converter. Its capacitor DAC has nine trial bits whose weights are not powers of two. Each conversion takes a fixed eleven clock cycles: one cycle to track the input, nine cycles to try bits from the top down, and one cycle to settle the final word. Conversions follow one another with no idle cycles, so the input clock must run at eleven times the wanted sample rate. For example, 176 MHz gives 16 MS/s.

The only analog input is one comparator decision bit. This bit is high when the sampled input lies above the level set by the present DAC word. The block drives the DAC switch word and a track-phase flag. It also publishes the nine raw decisions and an 8-bit binary value, formed by adding the weights of the kept bits. Because the weights overlap, a wrong decision on an upper bit can be repaired by the lower bits. The comparator, the capacitor array and the reference and common-mode biases stay outside the block.

Top module: `sar_redundant_ctrl`

## Requirements
- R1: While reset is held, `sample_o` is 1 and `dac_o`, `raw_o`, `result_o` and `valid_o` are all 0.
- R2: `sample_o` is high for exactly one cycle in every 11 cycles, and conversions run back to back.
- R3: In the k-th cycle after the track cycle (k = 1..9), `dac_o` bit 9-k is 1 and all lower bits are 0. `dac_o` is all zero during the track cycle.
- R4: At the end of each trial cycle, the bit under trial keeps the value of `comp_i`. Higher bits hold their earlier decisions. In cycle 10, `dac_o` shows the final nine decisions.
- R5: `valid_o` pulses for one cycle, in the track cycle of the next conversion, 11 cycles after the previous pulse. In that cycle `raw_o` equals the final decision word.
- R6: `result_o` is the smaller of 255 and the sum of the weights of the set `raw_o` bits. From bit 8 down to bit 0 the weights are 112, 64, 36, 20, 12, 6, 3, 2, 1.
- R7: With an ideal comparator, every input code from 0 to 255 converts to within ±1 of itself.
- R8: For inputs from 112 to 144, a wrongly cleared top decision is repaired by the lower bits, and the result still matches the input.
- R9: `comp_i` has no effect during the track cycle or during cycle 10.
- R10: When all nine decisions are kept, `raw_o` is 0x1FF and `result_o` saturates to 255.
- R11: `raw_o` and `result_o` stay unchanged between `valid_o` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock, 11 times the sample rate |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised inside the block |
| comp_i | input | 1 | Comparator decision: 1 when the input is above the DAC level |
| dac_o | output | 9 | DAC trial and switch word |
| sample_o | output | 1 | High during the track cycle |
| raw_o | output | 9 | Raw decision word of the last conversion |
| result_o | output | 8 | Binary result of the last conversion, saturated |
| valid_o | output | 1 | One-cycle strobe when `raw_o` and `result_o` are updated |

## Verification
A phase counter that skips or repeats a state moves the `sample_o` and `valid_o` spacing away from 11 cycles. This shows at the very next track cycle. A wrong index decode in the trial register shows as a wrong bit in `dac_o` in that same trial cycle. The bench compares the DAC word against its own greedy model on every cycle of every conversion. A weight or saturation fault shows only in `result_o` at the next strobe. The full sweep of input codes, the all-ones case and the repaired-decision cases make sure every weight contributes.

// File: rtl/sar_ctrl_pkg.sv
package sar_ctrl_pkg;
  localparam int unsigned NTRIAL = 9;
  localparam int unsigned OUT_W  = 8;

  // Capacitor weight of a trial bit, indexed from the least significant bit.
  function automatic int unsigned bit_weight(input int unsigned idx);
    case (idx)
      8:       bit_weight = 112;
      7:       bit_weight = 64;
      6:       bit_weight = 36;
      5:       bit_weight = 20;
      4:       bit_weight = 12;
      3:       bit_weight = 6;
      2:       bit_weight = 3;
      1:       bit_weight = 2;
      default: bit_weight = 1;
    endcase
  endfunction

  function automatic int unsigned weight_total(input int unsigned n);
    int unsigned acc;
    acc = 0;
    for (int unsigned i = 0; i < n; i++) acc += bit_weight(i);
    weight_total = acc;
  endfunction

  localparam int unsigned SUM_MAX = weight_total(NTRIAL);
  localparam int unsigned SUM_W   = $clog2(SUM_MAX + 1);
  localparam int unsigned PERIOD  = NTRIAL + 2;
  localparam int unsigned IDX_W   = $clog2(NTRIAL + 1);
endpackage

// File: rtl/sar_phase_seq.sv
module sar_phase_seq #(
  parameter int unsigned NTRIAL = 9,
  parameter int unsigned IDX_W  = $clog2(NTRIAL + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic             sample_o,
  output logic             trial_o,
  output logic             latch_o,
  output logic [IDX_W-1:0] idx_o
);
  localparam int unsigned LAST = NTRIAL + 1;
  localparam int unsigned PH_W = $clog2(LAST + 1);

  logic [PH_W-1:0] ph_q;
  logic [PH_W-1:0] ph_d;

  always_comb begin
    if (ph_q == PH_W'(LAST)) ph_d = '0;
    else                     ph_d = ph_q + PH_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= '0;
    else        ph_q <= ph_d;
  end

  always_comb begin
    sample_o = (ph_q == '0);
    latch_o  = (ph_q == PH_W'(LAST));
    trial_o  = !sample_o && !latch_o;
    idx_o    = IDX_W'(PH_W'(NTRIAL) - ph_q);
  end
endmodule

// File: rtl/sar_trial_reg.sv
module sar_trial_reg #(
  parameter int unsigned NTRIAL = 9,
  parameter int unsigned IDX_W  = $clog2(NTRIAL + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_i,
  input  logic              trial_i,
  input  logic              latch_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              comp_i,
  output logic [NTRIAL-1:0] dac_o
);
  logic [NTRIAL-1:0] dac_q;
  logic [NTRIAL-1:0] dac_d;

  for (genvar i = 0; i < NTRIAL; i++) begin : g_bit
    logic bit_d;
    always_comb begin
      bit_d = dac_q[i];
      if (sample_i)                                bit_d = (i == NTRIAL - 1);
      else if (latch_i)                            bit_d = 1'b0;
      else if (trial_i && idx_i == IDX_W'(i))      bit_d = comp_i;
      else if (trial_i && idx_i == IDX_W'(i + 1))  bit_d = 1'b1;
    end
    assign dac_d[i] = bit_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dac_q <= '0;
    else        dac_q <= dac_d;
  end

  assign dac_o = dac_q;
endmodule

// File: rtl/sar_weight_sum.sv
module sar_weight_sum
  import sar_ctrl_pkg::*;
#(
  parameter int unsigned NB   = NTRIAL,
  parameter int unsigned OW   = OUT_W,
  parameter int unsigned SW   = SUM_W
) (
  input  logic [NB-1:0] word_i,
  output logic [OW-1:0] bin_o
);
  localparam int unsigned OUT_MAX = (1 << OW) - 1;

  logic [SW-1:0] acc;

  always_comb begin
    acc = '0;
    for (int unsigned i = 0; i < NB; i++) begin
      if (word_i[i]) acc = acc + SW'(bit_weight(i));
    end
    if (acc > SW'(OUT_MAX)) bin_o = '1;
    else                    bin_o = acc[OW-1:0];
  end
endmodule

// File: rtl/sar_result_reg.sv
module sar_result_reg #(
  parameter int unsigned NB = 9,
  parameter int unsigned OW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_en,
  input  logic [NB-1:0] raw_d,
  input  logic [OW-1:0] bin_d,
  output logic [NB-1:0] raw_o,
  output logic [OW-1:0] bin_o,
  output logic          valid_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_o <= '0;
      bin_o <= '0;
    end else if (load_en) begin
      raw_o <= raw_d;
      bin_o <= bin_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_o <= 1'b0;
    else        valid_o <= load_en;
  end
endmodule

// File: rtl/sar_redundant_ctrl.sv
module sar_redundant_ctrl
  import sar_ctrl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              comp_i,
  output logic [NTRIAL-1:0] dac_o,
  output logic              sample_o,
  output logic [NTRIAL-1:0] raw_o,
  output logic [OUT_W-1:0]  result_o,
  output logic              valid_o
);
  logic             rst_s0;
  logic             rst_sync_n;
  logic             trial;
  logic             latch;
  logic [IDX_W-1:0] idx;
  logic [OUT_W-1:0] bin_now;

  // Reset asserts at once and releases two edges later.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s0     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_s0     <= 1'b1;
      rst_sync_n <= rst_s0;
    end
  end

  sar_phase_seq #(.NTRIAL(NTRIAL), .IDX_W(IDX_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .sample_o (sample_o),
    .trial_o  (trial),
    .latch_o  (latch),
    .idx_o    (idx)
  );

  sar_trial_reg #(.NTRIAL(NTRIAL), .IDX_W(IDX_W)) u_trial (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .sample_i (sample_o),
    .trial_i  (trial),
    .latch_i  (latch),
    .idx_i    (idx),
    .comp_i   (comp_i),
    .dac_o    (dac_o)
  );

  sar_weight_sum #(.NB(NTRIAL), .OW(OUT_W), .SW(SUM_W)) u_sum (
    .word_i (dac_o),
    .bin_o  (bin_now)
  );

  sar_result_reg #(.NB(NTRIAL), .OW(OUT_W)) u_res (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .load_en (latch),
    .raw_d   (dac_o),
    .bin_d   (bin_now),
    .raw_o   (raw_o),
    .bin_o   (result_o),
    .valid_o (valid_o)
  );
endmodule

// File: rtl/sar_redundant_ctrl_chk.sv
module sar_redundant_ctrl_chk
  import sar_ctrl_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [NTRIAL-1:0] dac_o,
  input logic              sample_o,
  input logic [NTRIAL-1:0] raw_o,
  input logic [OUT_W-1:0]  result_o,
  input logic              valid_o
);
  logic [7:0] gap_q;
  logic       seen_q;
  logic       armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q   <= '0;
      seen_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      armed_q <= 1'b1;
      if (sample_o) begin
        gap_q  <= '0;
        seen_q <= 1'b1;
      end else begin
        gap_q <= gap_q + 8'd1;
      end
    end
  end

  p_period_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_o && seen_q) |-> (gap_q == 8'(PERIOD - 1)));

  p_single_track_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sample_o |=> !sample_o);

  p_dac_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sample_o |-> (dac_o == '0));

  p_msb_trial_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && $past(sample_o)) |-> (dac_o == NTRIAL'(1) << (NTRIAL - 1)));

  p_valid_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);

  p_valid_in_track_r5: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> sample_o);

  p_raw_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (raw_o == $past(dac_o)));

  p_saturate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && raw_o == '1) |-> (result_o == '1));

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> ($stable(result_o) && $stable(raw_o)));
endmodule

bind sar_redundant_ctrl sar_redundant_ctrl_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .dac_o    (dac_o),
  .sample_o (sample_o),
  .raw_o    (raw_o),
  .result_o (result_o),
  .valid_o  (valid_o)
);

// File: tb/sar_redundant_ctrl_bench.sv
module sar_redundant_ctrl_bench;
  logic       clk;
  logic       rst_n;
  logic       comp;
  logic [8:0] dac_o;
  logic       sample_o;
  logic [8:0] raw_o;
  logic [7:0] result_o;
  logic       valid_o;

  int checks;
  int fails;
  int x_code;
  int mode;   // 0 ideal, 1 force top decision low, 2 always high, 3 junk in idle phases
  int tph;
  bit done;

  sar_redundant_ctrl u_sar_redundant_ctrl (
    .clk(clk), .rst_n(rst_n), .comp_i(comp), .dac_o(dac_o),
    .sample_o(sample_o), .raw_o(raw_o), .result_o(result_o), .valid_o(valid_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic int wt(input int b);
    int t[9] = '{1, 2, 3, 6, 12, 20, 36, 64, 112};
    return t[b];
  endfunction

  function automatic int wsum(input logic [8:0] w);
    int s = 0;
    for (int b = 0; b < 9; b++) if (w[b]) s += wt(b);
    return s;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Behavioural comparator, updated away from the active edge.
  always @(negedge clk) begin
    logic c;
    tph = sample_o ? 0 : tph + 1;
    c = (x_code >= wsum(dac_o));
    if (mode == 1 && tph == 1) c = 1'b0;
    if (mode == 2) c = 1'b1;
    if (mode == 3 && (sample_o || tph == 10)) c = 1'b1;
    comp = c;
  end

  // Called at a negedge inside a track cycle; returns at the next one.
  task automatic convert(input int xv, input int md, input int exp_res, input string req);
    int d = 0;
    logic [7:0] prev_res = result_o;
    logic [8:0] prev_raw = raw_o;
    x_code = xv;
    mode = md;
    for (int k = 1; k <= 11; k++) begin
      @(negedge clk);
      if (k <= 9) begin
        int trial = d | (1 << (9 - k));
        bit keep;
        check(dac_o == 9'(trial), "R3 trial word", int'(dac_o), trial);
        keep = (xv >= wsum(9'(trial)));
        if (md == 1 && k == 1) keep = 1'b0;
        if (md == 2) keep = 1'b1;
        if (keep) d = trial;
      end
      if (k == 10) check(dac_o == 9'(d), "R4 final decisions", int'(dac_o), d);
      if (k <= 10) begin
        check(!valid_o && !sample_o, "R2 no strobe mid-conversion", int'(valid_o), 0);
        check(result_o == prev_res && raw_o == prev_raw, "R11 hold", int'(result_o), int'(prev_res));
      end
    end
    check(valid_o && sample_o, "R5 strobe after 11 cycles", int'(valid_o), 1);
    check(raw_o == 9'(d), "R5 raw word", int'(raw_o), d);
    begin
      int s = wsum(raw_o);
      int e6 = (s > 255) ? 255 : s;
      check(int'(result_o) == e6, "R6 weighted sum", int'(result_o), e6);
    end
    if (exp_res >= 0) begin
      int diff = int'(result_o) - exp_res;
      check(diff <= 1 && diff >= -1, req, int'(result_o), exp_res);
    end
    @(negedge clk);
    check(!valid_o, "R5 one-cycle strobe", int'(valid_o), 0);
    // realign to the next track cycle
    while (!sample_o) @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    checks = 0; fails = 0; x_code = 0; mode = 0; tph = 0; done = 0;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    check(sample_o == 1'b1, "R1 sample in reset", int'(sample_o), 1);
    check(dac_o == 0 && raw_o == 0, "R1 words clear", int'(dac_o), 0);
    check(result_o == 0 && valid_o == 0, "R1 result clear", int'(result_o), 0);
    rst_n = 1'b1;
    while (!valid_o) @(negedge clk);
    // R7 full sweep with an ideal comparator
    for (int v = 0; v < 256; v++) convert(v, 0, v, "R7 sweep");
    // R8 wrong top decision repaired
    for (int v = 112; v <= 144; v++) convert(v, 1, v, "R8 redundancy");
    // R10 every decision kept
    convert(0, 2, 255, "R10 saturation");
    check(raw_o == 9'h1FF, "R10 raw all ones", int'(raw_o), 511);
    // R9 comparator ignored in idle phases
    convert(0, 3, 0, "R9 ignored input");
    convert(100, 3, 100, "R9 ignored input");
    convert(255, 0, 255, "R7 top code");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule